// File: doc/BRIEF.md
# LRU Stack-Distance Profiler

This block observes a stream of word addresses and keeps, in registers, a bounded recency stack of the distinct frames touched most recently. For every accepted reference it reports where that frame sat in the stack. Position 1 is the most recent entry, so the position is the reuse distance plus one. A frame that is absent from the stack is reported with a not-found flag. The frame is then placed on top, and every entry that was above its old slot moves down by one place.

A right shift applied to the address turns words into frames of 2^shift words, so that line-granular locality can be measured. Several capacity thresholds can be programmed. Each threshold has its own saturating miss counter, which gives the miss count of a fully associative LRU cache of that many frames. All capacities are measured in one pass over the stream. A reference counter supplies the denominator for the miss rate.

Fill state machine: ST_EMPTY (no entries) moves to ST_FILL on the first accepted reference. ST_FILL moves to ST_FULL when a not-found reference arrives while DEPTH_K-1 entries are held. ST_FULL persists: each not-found reference there pushes the bottom entry out. A clear or a reset sends any state back to ST_EMPTY.

Top module: `lru_depth_profiler`

## Requirements
- R1: Reset, or a synchronous `clear`, empties the stack, zeroes every counter and drops `dep_valid`. When `clear` and `ref_valid` are high in the same cycle, `clear` wins: that reference is neither reported nor counted, and it is not stored.
- R2: A reference sampled at a clock edge is reported at that same edge. `dep_valid` is high for exactly the following cycle. References are accepted in every cycle, with no gap required between them.
- R3: A reference whose frame is not in the stack sets `dep_not_found`=1 and `dep_value`=0, and the frame becomes the top entry.
- R4: A reference whose frame is held at position p (1 = most recent) reports `dep_value`=p and `dep_not_found`=0. The frame moves to position 1, and entries at positions 1..p-1 each move down one place. For a frame accessed earlier, p equals the number of distinct other frames referenced since that earlier access, plus one.
- R5: Frames are compared as `ref_addr >> frame_shift`. Addresses that differ only in the low `frame_shift` bits hit the same entry.
- R6: The stack holds at most DEPTH_K frames. A not-found reference into a full stack discards the entry at position DEPTH_K. A later reference to the discarded frame reports not-found.
- R7: Miss counter c (bits [c*CNT_W +: CNT_W] of `miss_counts`) increments on a reported reference when the frame is not found or when its depth exceeds capacity c (bits [c*DW +: DW] of `cap_limits`). The counter is unchanged otherwise.
- R8: Every counter saturates at its all-ones value and stays there until a clear or a reset.
- R9: `ref_total` increments once per reported reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous empty-and-zero command |
| ref_valid | input | 1 | Reference present |
| ref_addr | input | ADDR_W | Word address of the reference |
| frame_shift | input | $clog2(ADDR_W) | Right shift giving frame number |
| cap_limits | input | NUM_CAP*DW | Packed capacity thresholds, DW = $clog2(DEPTH_K+1) |
| dep_valid | output | 1 | Report for the previous cycle's reference |
| dep_not_found | output | 1 | Frame was absent from the stack |
| dep_value | output | DW | Stack depth 1..DEPTH_K, 0 when not found |
| miss_counts | output | NUM_CAP*CNT_W | Packed saturating miss counters |
| ref_total | output | CNT_W | Saturating reference counter |

## Verification
The event of interest is a synchronous clear that lands in the same cycle as a valid reference. The bench fills the stack, then raises both inputs together on one edge. It then expects no report and zero counters, and expects that the same address afterwards comes back as not-found, so the dropped reference left nothing behind. The second collision is a hit on the bottom entry of a full stack: the full-width shift and the state machine staying in ST_FULL take effect together. Cyclic sweeps with one to DEPTH_K+1 distinct frames give this case, and their depths and miss counts are worked out by formula.

// File: rtl/lru_prof_pkg.sv
package lru_prof_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FILL  = 2'd1,
        ST_FULL  = 2'd2
    } fill_state_e;
endpackage

// File: rtl/lru_match_array.sv
module lru_match_array #(
    parameter int ADDR_W  = 32,
    parameter int DEPTH_K = 16,
    parameter int IDX_W   = $clog2(DEPTH_K),
    parameter int OCC_W   = $clog2(DEPTH_K + 1)
) (
    input  logic [DEPTH_K-1:0][ADDR_W-1:0] entries,
    input  logic [OCC_W-1:0]               occ,
    input  logic [ADDR_W-1:0]              key,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx
);
    logic [DEPTH_K-1:0] match_vec;

    for (genvar g = 0; g < DEPTH_K; g++) begin : g_cmp
        assign match_vec[g] = (OCC_W'(g) < occ) && (entries[g] == key);
    end

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = DEPTH_K - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/lru_stack_regs.sv
module lru_stack_regs import lru_prof_pkg::*; #(
    parameter int ADDR_W  = 32,
    parameter int DEPTH_K = 16,
    parameter int IDX_W   = $clog2(DEPTH_K),
    parameter int OCC_W   = $clog2(DEPTH_K + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clear,
    input  logic                           upd,
    input  logic [ADDR_W-1:0]              key,
    input  logic                           hit,
    input  logic [IDX_W-1:0]               hit_idx,
    output logic [DEPTH_K-1:0][ADDR_W-1:0] entries,
    output logic [OCC_W-1:0]               occ
);
    fill_state_e state_q, state_d;
    logic        grow;
    logic [IDX_W-1:0] shift_lim;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = ST_EMPTY;
        end else begin
            unique case (state_q)
                ST_EMPTY: if (upd) state_d = ST_FILL;
                ST_FILL:  if (upd && !hit && occ == OCC_W'(DEPTH_K - 1)) state_d = ST_FULL;
                ST_FULL:  state_d = ST_FULL;
                default:  state_d = ST_EMPTY;
            endcase
        end
    end

    always_comb begin
        grow      = upd && !hit && (state_q != ST_FULL);
        shift_lim = hit ? hit_idx : IDX_W'(DEPTH_K - 1);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            occ <= '0;
        end else if (grow) begin
            occ <= occ + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            entries <= '0;
        end else if (upd && !clear) begin
            entries[0] <= key;
            for (int i = 1; i < DEPTH_K; i++) begin
                if (IDX_W'(i) <= shift_lim) entries[i] <= entries[i-1];
            end
        end
    end

    // R6
    occ_bound_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(DEPTH_K));

    // R6
    full_state_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FULL) |-> (occ == OCC_W'(DEPTH_K)));

    // R3
    top_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && !clear) |=> (entries[0] == $past(key)) && (occ != '0));

    // R1
    clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (occ == '0) && (state_q == ST_EMPTY));
endmodule

// File: rtl/lru_miss_counters.sv
module lru_miss_counters #(
    parameter int NUM_CAP = 4,
    parameter int DW      = 5,
    parameter int CNT_W   = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clear,
    input  logic                          upd,
    input  logic                          hit,
    input  logic [DW-1:0]                 depth,
    input  logic [NUM_CAP-1:0][DW-1:0]    caps,
    output logic [NUM_CAP-1:0][CNT_W-1:0] miss_q,
    output logic [CNT_W-1:0]              total_q
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            total_q <= '0;
        end else if (upd && total_q != '1) begin
            total_q <= total_q + 1'b1;
        end
    end

    for (genvar c = 0; c < NUM_CAP; c++) begin : g_cap
        logic is_miss;
        assign is_miss = upd && (!hit || depth > caps[c]);

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                miss_q[c] <= '0;
            end else if (is_miss && miss_q[c] != '1) begin
                miss_q[c] <= miss_q[c] + 1'b1;
            end
        end

        // R8
        miss_sat_chk: assert property (@(posedge clk) disable iff (rst)
            ($past(miss_q[c]) == '1 && !$past(clear)) |-> (miss_q[c] == '1));

        // R7
        miss_step_chk: assert property (@(posedge clk) disable iff (rst)
            (miss_q[c] == $past(miss_q[c])) || (miss_q[c] == $past(miss_q[c]) + 1'b1)
            || (miss_q[c] == '0));
    end

    // R9
    total_step_chk: assert property (@(posedge clk) disable iff (rst)
        (upd && !clear && total_q != '1) |=> (total_q == $past(total_q) + 1'b1));
endmodule

// File: rtl/lru_depth_profiler.sv
module lru_depth_profiler #(
    parameter int ADDR_W  = 32,
    parameter int DEPTH_K = 16,
    parameter int NUM_CAP = 4,
    parameter int CNT_W   = 32,
    localparam int SH_W   = $clog2(ADDR_W),
    localparam int DW     = $clog2(DEPTH_K + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     ref_valid,
    input  logic [ADDR_W-1:0]        ref_addr,
    input  logic [SH_W-1:0]          frame_shift,
    input  logic [NUM_CAP*DW-1:0]    cap_limits,
    output logic                     dep_valid,
    output logic                     dep_not_found,
    output logic [DW-1:0]            dep_value,
    output logic [NUM_CAP*CNT_W-1:0] miss_counts,
    output logic [CNT_W-1:0]         ref_total
);
    localparam int IDX_W = $clog2(DEPTH_K);
    localparam int OCC_W = $clog2(DEPTH_K + 1);

    logic                           upd;
    logic [ADDR_W-1:0]              key;
    logic [DEPTH_K-1:0][ADDR_W-1:0] entries;
    logic [OCC_W-1:0]               occ;
    logic                           hit;
    logic [IDX_W-1:0]               hit_idx;
    logic [DW-1:0]                  depth;
    logic [NUM_CAP-1:0][DW-1:0]     caps_pk;
    logic [NUM_CAP-1:0][CNT_W-1:0]  miss_pk;

    assign upd         = ref_valid && !clear;
    assign key         = ref_addr >> frame_shift;
    assign depth       = DW'(hit_idx) + 1'b1;
    assign caps_pk     = cap_limits;
    assign miss_counts = miss_pk;

    lru_match_array #(.ADDR_W(ADDR_W), .DEPTH_K(DEPTH_K), .IDX_W(IDX_W), .OCC_W(OCC_W)) match_i (
        .entries (entries),
        .occ     (occ),
        .key     (key),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    lru_stack_regs #(.ADDR_W(ADDR_W), .DEPTH_K(DEPTH_K), .IDX_W(IDX_W), .OCC_W(OCC_W)) stack_i (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .upd     (upd),
        .key     (key),
        .hit     (hit),
        .hit_idx (hit_idx),
        .entries (entries),
        .occ     (occ)
    );

    lru_miss_counters #(.NUM_CAP(NUM_CAP), .DW(DW), .CNT_W(CNT_W)) count_i (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .upd     (upd),
        .hit     (hit),
        .depth   (depth),
        .caps    (caps_pk),
        .miss_q  (miss_pk),
        .total_q (ref_total)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dep_valid     <= 1'b0;
            dep_not_found <= 1'b0;
            dep_value     <= '0;
        end else begin
            dep_valid     <= upd;
            dep_not_found <= upd && !hit;
            dep_value     <= (upd && hit) ? depth : '0;
        end
    end

    // R2
    report_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (ref_valid && !clear) |=> dep_valid);

    // R1
    clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> !dep_valid && (ref_total == '0));

    // R3
    nf_flag_chk: assert property (@(posedge clk) disable iff (rst)
        dep_not_found |-> dep_valid && (dep_value == '0));

    // R4
    depth_range_chk: assert property (@(posedge clk) disable iff (rst)
        (dep_valid && !dep_not_found) |-> (dep_value >= DW'(1)) && (dep_value <= DW'(DEPTH_K)));

    for (genvar c = 0; c < NUM_CAP; c++) begin : g_nf_miss
        // R7
        nf_counts_chk: assert property (@(posedge clk) disable iff (rst)
            (dep_valid && dep_not_found) |->
            (miss_pk[c] == $past(miss_pk[c]) + 1'b1) || (miss_pk[c] == '1));
    end
endmodule

// File: tb/lru_depth_profiler_tb.sv
`timescale 1ns/1ps
module lru_depth_profiler_tb_top;
    localparam int AW = 12;
    localparam int K  = 8;
    localparam int NC = 4;
    localparam int CW = 6;
    localparam int DW = 4;
    localparam int SW = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clear = 1'b0;
    logic ref_valid = 1'b0;
    logic [AW-1:0] ref_addr = '0;
    logic [SW-1:0] frame_shift = '0;
    logic [NC*DW-1:0] cap_limits = {4'd8, 4'd4, 4'd2, 4'd1};
    logic dep_valid, dep_not_found;
    logic [DW-1:0] dep_value;
    logic [NC*CW-1:0] miss_counts;
    logic [CW-1:0] ref_total;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lru_depth_profiler #(.ADDR_W(AW), .DEPTH_K(K), .NUM_CAP(NC), .CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .clear(clear), .ref_valid(ref_valid), .ref_addr(ref_addr),
        .frame_shift(frame_shift), .cap_limits(cap_limits), .dep_valid(dep_valid),
        .dep_not_found(dep_not_found), .dep_value(dep_value), .miss_counts(miss_counts),
        .ref_total(ref_total)
    );

    function automatic int miss_of(input int c);
        return int'(miss_counts[c*CW +: CW]);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(input int a, input bit exp_nf, input int exp_d, input string tag);
        ref_valid = 1'b1;
        ref_addr  = a[AW-1:0];
        @(negedge clk);
        check(dep_valid == 1'b1, {tag, " valid"}, int'(dep_valid), 1);
        if (exp_nf)
            check(dep_not_found == 1'b1 && dep_value == 0, {tag, " not-found"}, int'(dep_not_found), 1);
        else
            check(dep_not_found == 1'b0 && int'(dep_value) == exp_d, {tag, " depth"}, int'(dep_value), exp_d);
    endtask

    task automatic idle();
        ref_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_clear();
        ref_valid = 1'b0;
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(dep_valid == 0, "R1 reset dep_valid", int'(dep_valid), 0);
        check(ref_total == 0, "R1 reset total", int'(ref_total), 0);
        for (int c = 0; c < NC; c++) check(miss_of(c) == 0, "R1 reset miss", miss_of(c), 0);

        // R3 R4 R6 R7 R9: cyclic sweeps over 1..K+1 distinct frames, 3 rounds
        for (int m = 1; m <= K + 1; m++) begin
            do_clear();
            for (int r = 0; r < 3; r++) begin
                for (int i = 0; i < m; i++) begin
                    string tag;
                    tag = (r == 0) ? "R3 first ref" : ((m > K) ? "R6 evicted" : "R4 reuse");
                    send((i + 1) * 8, (r == 0) || (m > K), m, tag);
                end
            end
            idle();
            check(dep_valid == 0, "R2 idle no report", int'(dep_valid), 0);
            check(int'(ref_total) == 3 * m, "R9 total", int'(ref_total), 3 * m);
            for (int c = 0; c < NC; c++) begin
                int capv, expm;
                capv = 1 << c;
                expm = (m > K) ? 3 * m : (m + ((m > capv) ? 2 * m : 0));
                check(miss_of(c) == expm, "R7 miss count", miss_of(c), expm);
            end
        end

        // R4 non-cyclic order: A B C B A C
        do_clear();
        send(100, 1, 0, "R4 A");
        send(200, 1, 0, "R4 B");
        send(300, 1, 0, "R4 C");
        send(200, 0, 2, "R4 B again");
        send(100, 0, 3, "R4 A again");
        send(300, 0, 3, "R4 C again");
        idle();

        // R5 frame grouping with shift 2
        do_clear();
        frame_shift = 4'd2;
        send('h10, 1, 0, "R5 frame 4");
        send('h11, 0, 1, "R5 same frame");
        send('h13, 0, 1, "R5 same frame top");
        send('h20, 1, 0, "R5 frame 8");
        send('h12, 0, 2, "R5 frame 4 depth");
        frame_shift = 4'd0;
        idle();

        // R1 clear wins over same-cycle reference
        send(77, 1, 0, "R1 prefill");
        ref_valid = 1'b1;
        ref_addr  = 12'd77;
        clear     = 1'b1;
        @(negedge clk);
        clear     = 1'b0;
        ref_valid = 1'b0;
        check(dep_valid == 0, "R1 clear drops report", int'(dep_valid), 0);
        check(ref_total == 0, "R1 clear zero total", int'(ref_total), 0);
        check(miss_of(0) == 0, "R1 clear zero miss", miss_of(0), 0);
        @(negedge clk);
        send(77, 1, 0, "R1 stack emptied");
        idle();
        check(ref_total == 1, "R1 dropped ref uncounted", int'(ref_total), 1);

        // R8 saturation: 72 not-found refs
        do_clear();
        for (int r = 0; r < 8; r++)
            for (int i = 0; i < K + 1; i++)
                send((i + 1) * 16, 1, 0, "R8 overflow stream");
        idle();
        check(int'(ref_total) == CMAX, "R8 total saturates", int'(ref_total), CMAX);
        for (int c = 0; c < NC; c++) check(miss_of(c) == CMAX, "R8 miss saturates", miss_of(c), CMAX);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule